// File: doc/BRIEF.md
# Filtered Receive Message FIFO

This block sits behind a bus frame decoder and keeps the frames and symbols that a host has asked to see. Each event arrives as a start strobe that carries a header word, a status word and a 64-bit timestamp. Payload bytes follow, one per valid strobe, and an end strobe closes the event. An acceptance filter makes its decision on the start strobe. It combines an 11-bit ID value and mask, per-channel enables, a symbol enable, and a choice between all frames and startup frames only. Accepted events go into a ring of message slots, and a message becomes visible only when its end strobe arrives.

The host reads the oldest unread message through a small word-addressed register window. The window holds the message count, the status, the two timestamp halves, the header and a 4-byte payload slice picked by a byte-select register. A write to the release register drops the oldest message and shows the next one. Payload bytes beyond the slot size are dropped. An accepted event that finds every slot occupied is discarded, and it sets a sticky lost flag that is cleared by reading it. A level interrupt reports not-empty, near-full and lost conditions.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset the message count (word 4) reads 0, the filter value (word 0), mask (word 1), source enables (word 2) and interrupt register (word 3) read 0, and `irq` is low.
- R2: For a frame, header bits 23:13 are the ID. Every ID bit whose mask bit (word 1, bits 10:0) is 0 must equal the filter value bit (word 0, bits 10:0). ID bits whose mask bit is 1 are not compared.
- R3: A frame is accepted only if all of the following hold: status bit 2 is set; the channel test passes, meaning source enable bit 0 with status bit 3 (channel A) or source enable bit 1 with status bit 4 (channel B); the type test passes, meaning source enable bit 3 (all frames) or source enable bit 4 together with header bit 24 (startup frame); and the ID test of R2 passes.
- R4: A symbol (status bit 0 wake or bit 1 CAS) is accepted exactly when source enable bit 2 is set. No ID or channel test applies to a symbol.
- R5: Messages are read back in arrival order. While the count is nonzero, word 5 returns the oldest message's status, words 6 and 7 return timestamp bits 31:0 and 63:32, and word 8 returns its 29-bit header.
- R6: The count rises by one in the cycle after an accepted event's end strobe. A write to word 11 lowers the count by one when it is nonzero and has no effect on an empty store.
- R7: Writing N to word 9 makes word 10 return payload bytes 4N+3..4N of the oldest message, with byte 4N in bits 7:0. Bytes that were never received read 0.
- R8: Only the first MAX_BYTES payload bytes of a message are kept. Later bytes are dropped, and positions at or beyond MAX_BYTES read 0.
- R9: An accepted event whose start finds DEPTH messages stored is discarded, the stored messages stay unchanged, and word 3 bit 31 becomes 1. A rejected event never sets that bit.
- R10: A read of word 3 returns the lost bit and then clears it.
- R11: `irq` is high when word 3 bit 0 is set and the count is nonzero, when word 3 bit 1 is set and the count is at least DEPTH-1, or when the lost bit is set. Otherwise `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sof | input | 1 | Start of an event; samples header, status and timestamp |
| in_header | input | 29 | Header word of the event |
| in_status | input | 6 | Status word of the event |
| in_ts | input | 64 | Timestamp of the event |
| in_byte_valid | input | 1 | Payload byte strobe |
| in_byte | input | 8 | Payload byte |
| in_eof | input | 1 | End of the current event |
| host_addr | input | 4 | Register word address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears the lost bit on word 3) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr, same cycle |
| irq | output | 1 | Level interrupt |

## Verification
A wrong read or write pointer surfaces within one release as a header, timestamp or payload word that belongs to a different message than the oldest one. A count that drifts by one shows up at once on the count word and in the cycle where the near-full interrupt rises or falls, so the interrupt pin is compared against the model on every clock. A filter fault appears as a count that fails to move after an end strobe. A lost flag that is stuck or never set is visible on the next read of the interrupt register.

// File: rtl/rxmf_pkg.sv
package rxmf_pkg;

    localparam int ID_W  = 11;
    localparam int HDR_W = 29;
    localparam int ST_W  = 6;
    localparam int TS_W  = 64;
    localparam int SRC_W = 5;

    // status bit positions
    localparam int ST_WAKE = 0;
    localparam int ST_CAS  = 1;
    localparam int ST_MSG  = 2;
    localparam int ST_CHA  = 3;
    localparam int ST_CHB  = 4;

    // source enable bit positions
    localparam int SRC_CHA     = 0;
    localparam int SRC_CHB     = 1;
    localparam int SRC_SYM     = 2;
    localparam int SRC_ALL     = 3;
    localparam int SRC_STARTUP = 4;

    // header fields
    localparam int HDR_STARTUP = 24;
    localparam int HDR_ID_LSB  = 13;

    typedef enum logic [3:0] {
        RA_ID_VAL   = 4'd0,
        RA_ID_MASK  = 4'd1,
        RA_SRC_EN   = 4'd2,
        RA_IRQ      = 4'd3,
        RA_COUNT    = 4'd4,
        RA_STATUS   = 4'd5,
        RA_TS_LO    = 4'd6,
        RA_TS_HI    = 4'd7,
        RA_HEADER   = 4'd8,
        RA_BYTE_SEL = 4'd9,
        RA_DATA     = 4'd10,
        RA_RELEASE  = 4'd11,
        RA_SPARE0   = 4'd12,
        RA_SPARE1   = 4'd13,
        RA_SPARE2   = 4'd14,
        RA_SPARE3   = 4'd15
    } reg_addr_e;

    typedef struct packed {
        logic [ST_W-1:0]  status;
        logic [HDR_W-1:0] header;
        logic [TS_W-1:0]  ts;
    } msg_meta_t;

    function automatic logic id_hit(input logic [ID_W-1:0] id,
                                    input logic [ID_W-1:0] val,
                                    input logic [ID_W-1:0] mask);
        return ((id ^ val) & ~mask) == '0;
    endfunction

endpackage

// File: rtl/rxmf_filter.sv
module rxmf_filter
    import rxmf_pkg::*;
(
    input  logic [ID_W-1:0]  id_val,
    input  logic [ID_W-1:0]  id_mask,
    input  logic [SRC_W-1:0] src_en,
    input  logic [ID_W-1:0]  frame_id,
    input  logic             startup_flag,
    input  logic [ST_W-1:0]  status,
    output logic             accept
);
    logic is_symbol;
    logic chan_ok;
    logic type_ok;
    logic id_ok;

    always_comb begin
        is_symbol = status[ST_WAKE] | status[ST_CAS];
        chan_ok   = (src_en[SRC_CHA] & status[ST_CHA]) |
                    (src_en[SRC_CHB] & status[ST_CHB]);
        type_ok   = src_en[SRC_ALL] | (src_en[SRC_STARTUP] & startup_flag);
        id_ok     = id_hit(frame_id, id_val, id_mask);
        if (is_symbol)
            accept = src_en[SRC_SYM];
        else
            accept = status[ST_MSG] & chan_ok & type_ok & id_ok;
    end
endmodule

// File: rtl/rxmf_store.sv
module rxmf_store
    import rxmf_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int MAX_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sof,
    input  logic                       accept,
    input  msg_meta_t                  meta_in,
    input  logic                       byte_valid,
    input  logic [7:0]                 byte_in,
    input  logic                       eof,
    input  logic                       release_req,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output msg_meta_t                  head_meta,
    output logic [MAX_BYTES*8-1:0]     head_pay,
    output logic                       overflow,
    output logic                       commit,
    output logic                       released
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int IDX_W = $clog2(MAX_BYTES+1);
    localparam int BI_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    msg_meta_t        meta_q [DEPTH];
    logic [7:0]       pay_q  [DEPTH][MAX_BYTES];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic             full, take, byte_take;

    always_comb begin
        full      = (count_q == CNT_W'(DEPTH));
        take      = sof & accept & ~full;
        overflow  = sof & accept & full;
        commit    = eof & active_q & ~sof;
        released  = release_req & (count_q != '0);
        byte_take = byte_valid & active_q & ~sof & ~eof & (idx_q < IDX_W'(MAX_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count_q  <= '0;
            active_q <= 1'b0;
            idx_q    <= '0;
        end else begin
            if (sof) begin
                active_q <= take;
                idx_q    <= '0;
            end else if (commit) begin
                active_q <= 1'b0;
            end else if (byte_take) begin
                idx_q <= idx_q + 1'b1;
            end
            if (commit)
                wr_ptr <= wr_ptr + 1'b1;
            if (released)
                rd_ptr <= rd_ptr + 1'b1;
            count_q <= count_q + CNT_W'(commit) - CNT_W'(released);
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            meta_q[wr_ptr] <= meta_in;
            for (int b = 0; b < MAX_BYTES; b++)
                pay_q[wr_ptr][b] <= 8'h00;
        end else if (byte_take) begin
            pay_q[wr_ptr][idx_q[BI_W-1:0]] <= byte_in;
        end
    end

    assign count     = count_q;
    assign head_meta = meta_q[rd_ptr];

    for (genvar gb = 0; gb < MAX_BYTES; gb++) begin : g_head
        assign head_pay[gb*8 +: 8] = pay_q[rd_ptr][gb];
    end
endmodule

// File: rtl/rxmf_regs.sv
module rxmf_regs
    import rxmf_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int MAX_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [3:0]                 host_addr,
    input  logic                       host_wr,
    input  logic                       host_rd,
    input  logic [31:0]                host_wdata,
    output logic [31:0]                host_rdata,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  msg_meta_t                  head_meta,
    input  logic [MAX_BYTES*8-1:0]     head_pay,
    input  logic                       overflow,
    output logic [ID_W-1:0]            id_val,
    output logic [ID_W-1:0]            id_mask,
    output logic [SRC_W-1:0]           src_en,
    output logic                       release_req,
    output logic [1:0]                 irq_en,
    output logic                       lost,
    output logic                       irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    reg_addr_e  addr;
    logic [7:0] sel_q;
    logic       has_msg;
    logic [31:0] window;

    assign addr        = reg_addr_e'(host_addr);
    assign has_msg     = (count != '0);
    assign release_req = host_wr & (addr == RA_RELEASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_val  <= '0;
            id_mask <= '0;
            src_en  <= '0;
            irq_en  <= '0;
            sel_q   <= '0;
            lost    <= 1'b0;
        end else begin
            if (host_wr) begin
                case (addr)
                    RA_ID_VAL:   id_val  <= host_wdata[ID_W-1:0];
                    RA_ID_MASK:  id_mask <= host_wdata[ID_W-1:0];
                    RA_SRC_EN:   src_en  <= host_wdata[SRC_W-1:0];
                    RA_IRQ:      irq_en  <= host_wdata[1:0];
                    RA_BYTE_SEL: sel_q   <= host_wdata[7:0];
                    default: ;
                endcase
            end
            if (overflow)
                lost <= 1'b1;
            else if (host_rd && addr == RA_IRQ)
                lost <= 1'b0;
        end
    end

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            int pos;
            pos = int'(sel_q) * 4 + k;
            window[k*8 +: 8] = (pos < MAX_BYTES) ? head_pay[(pos % MAX_BYTES)*8 +: 8] : 8'h00;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (addr)
            RA_ID_VAL:   host_rdata = 32'(id_val);
            RA_ID_MASK:  host_rdata = 32'(id_mask);
            RA_SRC_EN:   host_rdata = 32'(src_en);
            RA_IRQ:      host_rdata = {lost, 29'd0, irq_en};
            RA_COUNT:    host_rdata = 32'(count);
            RA_STATUS:   host_rdata = has_msg ? 32'(head_meta.status) : '0;
            RA_TS_LO:    host_rdata = has_msg ? head_meta.ts[31:0] : '0;
            RA_TS_HI:    host_rdata = has_msg ? head_meta.ts[63:32] : '0;
            RA_HEADER:   host_rdata = has_msg ? 32'(head_meta.header) : '0;
            RA_BYTE_SEL: host_rdata = 32'(sel_q);
            RA_DATA:     host_rdata = has_msg ? window : '0;
            default:     host_rdata = '0;
        endcase
    end

    assign irq = (irq_en[0] & has_msg) |
                 (irq_en[1] & (count >= CNT_W'(DEPTH-1))) |
                 lost;
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
    import rxmf_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int MAX_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_sof,
    input  logic [28:0] in_header,
    input  logic [5:0]  in_status,
    input  logic [63:0] in_ts,
    input  logic        in_byte_valid,
    input  logic [7:0]  in_byte,
    input  logic        in_eof,
    input  logic [3:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [ID_W-1:0]        id_val_w, id_mask_w;
    logic [SRC_W-1:0]       src_en_w;
    logic                   accept_w;
    msg_meta_t              meta_w, head_meta_w;
    logic [MAX_BYTES*8-1:0] head_pay_w;
    logic [CNT_W-1:0]       count_w;
    logic                   overflow_w, commit_w, released_w, release_req_w, lost_w;
    logic [1:0]             irq_en_w;

    assign meta_w = '{status: in_status, header: in_header, ts: in_ts};

    rxmf_filter u_filter (
        .id_val       (id_val_w),
        .id_mask      (id_mask_w),
        .src_en       (src_en_w),
        .frame_id     (in_header[HDR_ID_LSB +: ID_W]),
        .startup_flag (in_header[HDR_STARTUP]),
        .status       (in_status),
        .accept       (accept_w)
    );

    rxmf_store #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .sof         (in_sof),
        .accept      (accept_w),
        .meta_in     (meta_w),
        .byte_valid  (in_byte_valid),
        .byte_in     (in_byte),
        .eof         (in_eof),
        .release_req (release_req_w),
        .count       (count_w),
        .head_meta   (head_meta_w),
        .head_pay    (head_pay_w),
        .overflow    (overflow_w),
        .commit      (commit_w),
        .released    (released_w)
    );

    rxmf_regs #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .count       (count_w),
        .head_meta   (head_meta_w),
        .head_pay    (head_pay_w),
        .overflow    (overflow_w),
        .id_val      (id_val_w),
        .id_mask     (id_mask_w),
        .src_en      (src_en_w),
        .release_req (release_req_w),
        .irq_en      (irq_en_w),
        .lost        (lost_w),
        .irq         (irq)
    );
endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       commit,
    input logic                       released,
    input logic                       overflow,
    input logic                       lost,
    input logic [1:0]                 irq_en,
    input logic                       irq
);
    // R6: count never exceeds the number of slots
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    // R6: a commit alone raises the count by one
    assert_commit_inc_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && !released) |=> (int'(count) == int'($past(count)) + 1));

    // R6: a release alone lowers the count by one
    assert_release_dec_R6: assert property (@(posedge clk) disable iff (rst)
        (released && !commit) |=> (int'(count) == int'($past(count)) - 1));

    // R9: overflow leaves the lost bit set
    assert_overflow_lost_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> lost);

    // R9: nothing is committed while all slots are occupied
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        !(commit && !released && int'(count) == DEPTH));

    // R11: not-empty interrupt
    assert_irq_nonempty_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_en[0] && count != '0) |-> irq);

    // R11: empty with no loss gives no interrupt
    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !lost) |-> !irq);
endmodule

bind rx_msg_fifo rx_msg_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .count    (count_w),
    .commit   (commit_w),
    .released (released_w),
    .overflow (overflow_w),
    .lost     (lost_w),
    .irq_en   (irq_en_w),
    .irq      (irq)
);

// File: tb/rx_msg_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_msg_fifo_tb_top;
    localparam int DEPTH = 4;
    localparam int MAXB  = 16;

    localparam logic [3:0] W_IDV = 4'd0, W_IDM = 4'd1, W_SRC = 4'd2, W_IRQ = 4'd3,
                           W_CNT = 4'd4, W_ST = 4'd5, W_TSL = 4'd6, W_TSH = 4'd7,
                           W_HDR = 4'd8, W_SEL = 4'd9, W_DAT = 4'd10, W_REL = 4'd11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_sof = 0, in_byte_valid = 0, in_eof = 0;
    logic [28:0] in_header = '0;
    logic [5:0]  in_status = '0;
    logic [63:0] in_ts = '0;
    logic [7:0]  in_byte = '0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 0, host_rd = 0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    always #2 clk = ~clk;

    rx_msg_fifo #(.DEPTH(DEPTH), .MAX_BYTES(MAXB)) dut_i (
        .clk(clk), .rst(rst), .in_sof(in_sof), .in_header(in_header),
        .in_status(in_status), .in_ts(in_ts), .in_byte_valid(in_byte_valid),
        .in_byte(in_byte), .in_eof(in_eof), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    typedef struct {
        logic [28:0] h;
        logic [5:0]  s;
        logic [63:0] t;
        logic [7:0]  b [MAXB];
    } msg_t;

    msg_t        q[$];
    logic [10:0] m_idv = 0, m_idm = 0;
    logic [4:0]  m_src = 0;
    logic [1:0]  m_en = 0;
    logic        m_lost = 0;
    int          checks = 0, failures = 0;
    bit          running = 0, done = 0;

    function automatic logic [28:0] mkhdr(input int id, input int len, input int cyc, input bit su);
        return (29'(id) << 13) | (29'(len) << 6) | 29'(cyc) | (29'(su) << 24);
    endfunction

    function automatic bit m_accept(input logic [28:0] h, input logic [5:0] s);
        bit idok, ch, ty;
        if (s[0] || s[1]) return m_src[2];
        idok = 1;
        for (int i = 0; i < 11; i++)
            if (!m_idm[i] && (h[13+i] != m_idv[i])) idok = 0;
        ch = (m_src[0] && s[3]) || (m_src[1] && s[4]);
        ty = m_src[3] || (m_src[4] && h[24]);
        return s[2] && ch && ty && idok;
    endfunction

    function automatic bit exp_irq();
        return (m_en[0] && q.size() > 0) || (m_en[1] && q.size() >= DEPTH-1) || m_lost;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R11: interrupt pin compared against the model on every clock
    always @(negedge clk) begin
        if (running && !done) check({31'd0, irq}, {31'd0, exp_irq()}, "R11 irq pin");
    end

    task automatic idle();
        in_sof = 0; in_byte_valid = 0; in_eof = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); idle();
        host_addr = a; host_wdata = d; host_wr = 1;
        @(posedge clk);
        case (a)
            W_IDV: m_idv = d[10:0];
            W_IDM: m_idm = d[10:0];
            W_SRC: m_src = d[4:0];
            W_IRQ: m_en  = d[1:0];
            W_REL: if (q.size() > 0) void'(q.pop_front());
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        @(negedge clk); idle();
        host_addr = a; host_rd = 1;
        #1 v = host_rdata;
        check(v, exp, tag);
        @(posedge clk);
        if (a == W_IRQ) m_lost = 0;
    endtask

    task automatic send(input logic [28:0] h, input logic [5:0] s, input logic [63:0] t,
                        input int n, input logic [7:0] base);
        bit store;
        msg_t m;
        @(negedge clk); idle();
        in_sof = 1; in_header = h; in_status = s; in_ts = t;
        @(posedge clk);
        store = m_accept(h, s);
        if (store && q.size() == DEPTH) begin m_lost = 1; store = 0; end
        m.h = h; m.s = s; m.t = t;
        for (int i = 0; i < MAXB; i++) m.b[i] = (i < n) ? 8'(base + 8'(i)) : 8'h00;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); idle();
            in_byte_valid = 1; in_byte = 8'(base + 8'(i));
            @(posedge clk);
        end
        @(negedge clk); idle();
        in_eof = 1;
        @(posedge clk);
        if (store) q.push_back(m);
    endtask

    task automatic check_head(input string tag);
        logic [31:0] w;
        rd(W_CNT, 32'(q.size()), {tag, " R6 count"});
        rd(W_HDR, 32'(q[0].h), {tag, " R5 header"});
        rd(W_ST, 32'(q[0].s), {tag, " R5 status"});
        rd(W_TSL, q[0].t[31:0], {tag, " R5 ts lo"});
        rd(W_TSH, q[0].t[63:32], {tag, " R5 ts hi"});
        for (int n = 0; n < 5; n++) begin
            wr(W_SEL, 32'(n));
            for (int k = 0; k < 4; k++)
                w[k*8 +: 8] = (n*4+k < MAXB) ? q[0].b[n*4+k] : 8'h00;
            rd(W_DAT, w, {tag, " R7 R8 data window"});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0; running = 1;

        // R1 reset state
        rd(W_CNT, 0, "R1 count");
        rd(W_IDV, 0, "R1 id value");
        rd(W_IDM, 0, "R1 id mask");
        rd(W_SRC, 0, "R1 source enables");
        rd(W_IRQ, 0, "R1 irq reg");

        // R3: with no source enabled a frame is dropped
        send(mkhdr(12'h012, 3, 1, 0), 6'b001100, 64'h1, 4, 8'h10);
        rd(W_CNT, 0, "R3 all sources off");

        wr(W_IDV, 32'h010);
        wr(W_IDM, 32'h00F);
        wr(W_SRC, 32'h0F);
        wr(W_IRQ, 32'h1);

        send(mkhdr(12'h012, 3, 5, 0), 6'b001100, 64'h1122334455667788, 6, 8'hA0);
        check_head("m1");
        send(mkhdr(12'h030, 2, 6, 0), 6'b001100, 64'h2, 4, 8'h30);
        rd(W_CNT, 1, "R2 masked id mismatch rejected");
        send(mkhdr(12'h01F, 2, 7, 0), 6'b010100, 64'h3, 3, 8'h50);
        rd(W_CNT, 2, "R2 mask boundary id accepted");
        send(mkhdr(12'h000, 0, 0, 0), 6'b000001, 64'h4, 0, 8'h00);
        rd(W_CNT, 3, "R4 wake symbol accepted without id match");
        wr(W_IRQ, 32'h3);
        send(mkhdr(12'h011, 10, 9, 1), 6'b010100, 64'hDEAD_BEEF_0000_0005, 20, 8'hC0);
        rd(W_CNT, 4, "R6 store full");
        send(mkhdr(12'h030, 1, 1, 0), 6'b001100, 64'h6, 2, 8'h70);
        rd(W_IRQ, 32'h3, "R9 rejected event while full leaves lost clear");
        send(mkhdr(12'h013, 1, 1, 0), 6'b001100, 64'h7, 2, 8'h80);
        rd(W_CNT, 4, "R9 overflow keeps count");
        rd(W_IRQ, 32'h8000_0003, "R9 lost bit set");
        rd(W_IRQ, 32'h0000_0003, "R10 lost bit cleared by read");

        // R5 order, contents intact after overflow
        for (int i = 0; i < 4; i++) begin
            check_head("drain");
            wr(W_REL, 0);
        end
        rd(W_CNT, 0, "R6 drained");
        wr(W_REL, 0);
        rd(W_CNT, 0, "R6 release on empty ignored");
        rd(W_HDR, 0, "R5 empty header reads zero");

        // R3 startup-only and channel gating, R4 symbols disabled
        wr(W_SRC, 32'h11);
        send(mkhdr(12'h014, 1, 2, 0), 6'b001100, 64'h8, 1, 8'h01);
        rd(W_CNT, 0, "R3 non-startup frame rejected");
        send(mkhdr(12'h014, 1, 2, 1), 6'b010100, 64'h9, 1, 8'h02);
        rd(W_CNT, 0, "R3 channel B disabled");
        send(mkhdr(12'h014, 1, 2, 1), 6'b001100, 64'hA, 1, 8'h03);
        rd(W_CNT, 1, "R3 startup frame on A accepted");
        send(mkhdr(12'h000, 0, 0, 0), 6'b000010, 64'hB, 0, 8'h00);
        rd(W_CNT, 1, "R4 CAS symbol rejected with symbols off");
        send(mkhdr(12'h014, 1, 2, 1), 6'b001000, 64'hC, 1, 8'h04);
        rd(W_CNT, 1, "R3 frame without message bit rejected");
        check_head("su");
        wr(W_REL, 0);
        wr(W_IRQ, 32'h0);
        rd(W_CNT, 0, "R6 final empty");

        @(negedge clk); idle();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule